// File: doc/BRIEF.md
# Ping-Pong Force Result Store

This block collects per-particle force results from a compute pipeline and hands them to a host-facing drain. Each result is three IEEE 754 single-precision words (x, y and z force). The block treats these words as opaque data. Storage is split into two equal banks. One bank fills while the other bank is read out. Records are appended in particle order, so the slot a record lands in is its position in the enumeration since the bank last became the fill bank.

Each bank has a live valid-entry counter. The counter supplies the append offset and is advanced by every accepted write. Each bank also keeps a 16-byte index row. The row carries the counter, the bank number and a generation count that advances each time the bank is recycled, and its last byte is a checksum of the other fifteen. The checksum is rebuilt in the same clock edge as every counter change, so the row is consistent in every cycle.

The drain side reads its bank through an address port. When it has finished with the bank, it gives the bank back by pulsing a release input. A swap exchanges the two roles. A swap happens on request, or by itself when a write finds the fill bank full. It is only allowed while the drain bank has been given back. A write that finds the fill bank full while the other bank is still held is lost, and it sets a sticky overflow flag.

Top module: `force_pingpong_store`

## Requirements
- R1: After reset, bank 0 is the fill bank, both counters are 0, both generations are 0, the drain bank is not held, the overflow flag is 0, and both index rows carry a valid checksum.
- R2: An accepted write stores {z,y,x} at offset equal to the fill counter's value before the edge, and the counter rises by exactly one at that edge.
- R3: Index row byte layout: byte 0 is counter bits 7:0, byte 1 is counter bits 15:8, byte 2 is the bank number, byte 3 is the generation, bytes 4 to 14 are zero, and byte 15 is the XOR of bytes 0 to 14. The row follows the counter in the same cycle.
- R4: A swap request is taken only while the drain bank is not held. A taken swap makes the other bank the fill bank, clears its counter, adds one to its generation, marks the old fill bank as held, and pulses swap_taken in the following cycle. A request made while the drain bank is held has no effect.
- R5: A write that finds the fill bank full while the drain bank is not held swaps the banks automatically, and the record lands at offset 0 of the new fill bank, whose counter then reads 1.
- R6: A write that finds the fill bank full while the drain bank is held is dropped: no counter changes. The overflow flag is then set and stays set until reset.
- R7: A drain read returns the three words stored at rd_addr in the drain bank one cycle after the address is presented. Any address at or beyond the drain bank's counter returns all zeros.
- R8: drain_release clears the held state of the drain bank. When the bank is not held, drain_release has no effect.
- R9: A swap request and a write in the same cycle, while the drain bank is not held, place the record at offset 0 of the new fill bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Append one force record |
| wr_fx | input | WORD_W | Force x word |
| wr_fy | input | WORD_W | Force y word |
| wr_fz | input | WORD_W | Force z word |
| swap_req | input | 1 | Request a role swap |
| drain_release | input | 1 | Drain side gives its bank back |
| rd_addr | input | CW | Drain read offset |
| rd_fx | output | WORD_W | Drained x word, one cycle after the address |
| rd_fy | output | WORD_W | Drained y word |
| rd_fz | output | WORD_W | Drained z word |
| fill_bank | output | 1 | Number of the current fill bank |
| fill_count | output | CW | Valid entries in the fill bank |
| drain_count | output | CW | Valid entries in the drain bank |
| drain_busy | output | 1 | Drain bank is held by the drain side |
| overflow | output | 1 | Sticky flag for a lost write |
| swap_taken | output | 1 | One-cycle pulse after a swap |
| fill_index | output | 128 | Index row of the fill bank |
| drain_index | output | 128 | Index row of the drain bank |

## Verification
The bench builds the store with DEPTH set to 4 and 32-bit words, so CW is 3. With this depth, only a few writes fill a bank. That puts automatic swaps, dropped writes and recycled generations within reach in the scripted part of the run. The run then continues with a long pseudo-random mix of writes, swap requests and releases. The 3-bit read address covers offsets 0 to 7, so every drain sweep also reads beyond the valid count and beyond the bank itself. After every cycle, a bench-side model of both banks, computed from the requirements, predicts all status outputs and both index rows, including each checksum.

// File: rtl/fsb_pkg.sv
package fsb_pkg;

  localparam int ROW_W    = 128;
  localparam int BODY_W   = 120;
  localparam int BODY_BYTES = 15;

  // Assemble bytes 0..14 of an index row
  function automatic logic [BODY_W-1:0] row_body(
    input logic [15:0] cnt,
    input logic [7:0]  bank_id,
    input logic [7:0]  gen
  );
    logic [BODY_W-1:0] b;
    b = '0;
    b[15:0]  = cnt;
    b[23:16] = bank_id;
    b[31:24] = gen;
    return b;
  endfunction

  // Byte-wise XOR fold of the row body
  function automatic logic [7:0] fold_xor(input logic [BODY_W-1:0] body);
    logic [7:0] acc;
    acc = 8'h00;
    for (int i = 0; i < BODY_BYTES; i++) begin
      acc = acc ^ body[8*i +: 8];
    end
    return acc;
  endfunction

endpackage

// File: rtl/fsb_bank.sv
module fsb_bank
  import fsb_pkg::*;
#(
  parameter int DEPTH   = 16,
  parameter int WORD_W  = 32,
  parameter int BANK_ID = 0
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             clear_i,
  input  logic                             wr_i,
  input  logic [3*WORD_W-1:0]              wr_data_i,
  input  logic [$clog2(DEPTH+1)-1:0]       rd_addr_i,
  output logic [3*WORD_W-1:0]              rd_data_o,
  output logic [$clog2(DEPTH+1)-1:0]       count_o,
  output logic [ROW_W-1:0]                 row_o
);

  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH+1);
  localparam int EW = 3*WORD_W;

  logic [EW-1:0] mem [DEPTH];
  logic [CW-1:0] count_q;
  logic [7:0]    gen_q;
  logic [7:0]    csum_q;

  // Next-state values for the counter and the generation
  logic [CW-1:0] cnt_nxt;
  logic [7:0]    gen_nxt;
  logic [AW-1:0] wr_slot;
  logic          touch;

  always_comb begin
    if (clear_i) begin
      cnt_nxt = wr_i ? CW'(1) : '0;
      gen_nxt = gen_q + 8'd1;
    end else begin
      cnt_nxt = count_q + CW'(1);
      gen_nxt = gen_q;
    end
  end

  assign touch   = clear_i | wr_i;
  assign wr_slot = clear_i ? '0 : count_q[AW-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count_q <= '0;
      gen_q   <= 8'd0;
      csum_q  <= fold_xor(row_body(16'd0, 8'(BANK_ID), 8'd0));
    end else if (touch) begin
      count_q <= cnt_nxt;
      gen_q   <= gen_nxt;
      csum_q  <= fold_xor(row_body(16'(cnt_nxt), 8'(BANK_ID), gen_nxt));
    end
  end

  always_ff @(posedge clk) begin
    if (wr_i) begin
      mem[wr_slot] <= wr_data_i;
    end
  end

  assign rd_data_o = mem[rd_addr_i[AW-1:0]];
  assign count_o   = count_q;
  assign row_o     = {csum_q, row_body(16'(count_q), 8'(BANK_ID), gen_q)};

  // R2: a plain append advances the counter by one
  p_count_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && !clear_i) |=> (count_o == $past(count_o) + CW'(1)));

  // R3: checksum byte always matches the other fifteen bytes
  p_row_csum_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (fold_xor(row_o[119:0]) == row_o[127:120]));

  // R4: recycling a bank without a write empties it
  p_clear_empty_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (clear_i && !wr_i) |=> (count_o == '0));

  // R6: no append ever reaches a full bank
  p_no_write_full_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && !clear_i) |-> (count_o < CW'(DEPTH)));

endmodule

// File: rtl/fsb_ctrl.sv
module fsb_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_en_i,
  input  logic swap_req_i,
  input  logic release_i,
  input  logic fill_full_i,
  output logic fill_sel_o,
  output logic tgt_sel_o,
  output logic busy_o,
  output logic ovf_o,
  output logic take_o,
  output logic wr_go_o,
  output logic swap_taken_o
);

  logic fill_sel_q;
  logic busy_q;
  logic ovf_q;
  logic taken_q;
  logic drop;

  // Swap is taken on request or on a write into a full bank
  assign take_o    = (swap_req_i | (wr_en_i & fill_full_i)) & ~busy_q;
  assign wr_go_o   = wr_en_i & (take_o | ~fill_full_i);
  assign drop      = wr_en_i & fill_full_i & ~take_o;
  assign tgt_sel_o = take_o ? ~fill_sel_q : fill_sel_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fill_sel_q <= 1'b0;
      busy_q     <= 1'b0;
      ovf_q      <= 1'b0;
      taken_q    <= 1'b0;
    end else begin
      taken_q <= take_o;
      if (take_o) begin
        fill_sel_q <= ~fill_sel_q;
        busy_q     <= 1'b1;
      end else if (release_i) begin
        busy_q     <= 1'b0;
      end
      if (drop) begin
        ovf_q <= 1'b1;
      end
    end
  end

  assign fill_sel_o   = fill_sel_q;
  assign busy_o       = busy_q;
  assign ovf_o        = ovf_q;
  assign swap_taken_o = taken_q;

  // R4: no swap while the drain bank is held
  p_swap_needs_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> !take_o);

  // R4: a taken swap flips the roles
  p_swap_flips_r4: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |=> (fill_sel_o != $past(fill_sel_o)) && busy_o && swap_taken_o);

  // R6: overflow is sticky
  p_no_overflow_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_o |=> ovf_o);

  // R8: a release frees a held bank
  p_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && release_i) |=> !busy_o);

endmodule

// File: rtl/force_pingpong_store.sv
module force_pingpong_store
  import fsb_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int WORD_W = 32,
  localparam int CW    = $clog2(DEPTH+1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_fx,
  input  logic [WORD_W-1:0] wr_fy,
  input  logic [WORD_W-1:0] wr_fz,
  input  logic              swap_req,
  input  logic              drain_release,
  input  logic [CW-1:0]     rd_addr,
  output logic [WORD_W-1:0] rd_fx,
  output logic [WORD_W-1:0] rd_fy,
  output logic [WORD_W-1:0] rd_fz,
  output logic              fill_bank,
  output logic [CW-1:0]     fill_count,
  output logic [CW-1:0]     drain_count,
  output logic              drain_busy,
  output logic              overflow,
  output logic              swap_taken,
  output logic [127:0]      fill_index,
  output logic [127:0]      drain_index
);

  localparam int EW = 3*WORD_W;

  logic          fill_sel;
  logic          drain_sel;
  logic          tgt_sel;
  logic          take;
  logic          wr_go;
  logic          fill_full;
  logic [1:0]    bank_clr;
  logic [1:0]    bank_wr;
  logic [EW-1:0] bank_rd  [2];
  logic [CW-1:0] bank_cnt [2];
  logic [127:0]  bank_row [2];
  logic [EW-1:0] wr_word;
  logic [EW-1:0] rd_q;

  assign wr_word   = {wr_fz, wr_fy, wr_fx};
  assign drain_sel = ~fill_sel;
  assign fill_full = (bank_cnt[fill_sel] == CW'(DEPTH));

  fsb_ctrl u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_en_i      (wr_en),
    .swap_req_i   (swap_req),
    .release_i    (drain_release),
    .fill_full_i  (fill_full),
    .fill_sel_o   (fill_sel),
    .tgt_sel_o    (tgt_sel),
    .busy_o       (drain_busy),
    .ovf_o        (overflow),
    .take_o       (take),
    .wr_go_o      (wr_go),
    .swap_taken_o (swap_taken)
  );

  for (genvar b = 0; b < 2; b++) begin : g_bank
    assign bank_clr[b] = take & (fill_sel != 1'(b));
    assign bank_wr[b]  = wr_go & (tgt_sel == 1'(b));

    fsb_bank #(
      .DEPTH   (DEPTH),
      .WORD_W  (WORD_W),
      .BANK_ID (b)
    ) u_bank (
      .clk       (clk),
      .rst_n     (rst_n),
      .clear_i   (bank_clr[b]),
      .wr_i      (bank_wr[b]),
      .wr_data_i (wr_word),
      .rd_addr_i (rd_addr),
      .rd_data_o (bank_rd[b]),
      .count_o   (bank_cnt[b]),
      .row_o     (bank_row[b])
    );
  end

  // Drain read: registered, zero beyond the valid count
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_q <= '0;
    end else if (rd_addr < bank_cnt[drain_sel]) begin
      rd_q <= bank_rd[drain_sel];
    end else begin
      rd_q <= '0;
    end
  end

  assign rd_fx       = rd_q[WORD_W-1:0];
  assign rd_fy       = rd_q[2*WORD_W-1:WORD_W];
  assign rd_fz       = rd_q[3*WORD_W-1:2*WORD_W];
  assign fill_bank   = fill_sel;
  assign fill_count  = bank_cnt[fill_sel];
  assign drain_count = bank_cnt[drain_sel];
  assign fill_index  = bank_row[fill_sel];
  assign drain_index = bank_row[drain_sel];

  // R7: out-of-range drain reads give zero
  p_rd_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_addr >= drain_count) |=> (rd_q == '0));

  // R5: a write into a full bank with an idle drain lands at offset 0
  p_auto_swap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && fill_full && !drain_busy) |=> (fill_count == CW'(1)) && swap_taken);

  // R6: a dropped write leaves the fill counter unchanged
  p_drop_keeps_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && fill_full && drain_busy) |=> (fill_count == $past(fill_count)) && overflow);

endmodule

// File: tb/force_pingpong_store_tb.sv
module force_pingpong_store_tb;

  localparam int D  = 4;
  localparam int W  = 32;
  localparam int CW = $clog2(D+1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [W-1:0] wr_fx = '0, wr_fy = '0, wr_fz = '0;
  logic swap_req = 1'b0, drain_release = 1'b0;
  logic [CW-1:0] rd_addr = '0;
  logic [W-1:0] rd_fx, rd_fy, rd_fz;
  logic fill_bank, drain_busy, overflow, swap_taken;
  logic [CW-1:0] fill_count, drain_count;
  logic [127:0] fill_index, drain_index;

  always #2 clk = ~clk;

  force_pingpong_store #(.DEPTH(D), .WORD_W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en),
    .wr_fx(wr_fx), .wr_fy(wr_fy), .wr_fz(wr_fz),
    .swap_req(swap_req), .drain_release(drain_release), .rd_addr(rd_addr),
    .rd_fx(rd_fx), .rd_fy(rd_fy), .rd_fz(rd_fz),
    .fill_bank(fill_bank), .fill_count(fill_count), .drain_count(drain_count),
    .drain_busy(drain_busy), .overflow(overflow), .swap_taken(swap_taken),
    .fill_index(fill_index), .drain_index(drain_index)
  );

  int n_vec = 0;
  int n_bad = 0;

  // Bench model built from the requirements
  logic [3*W-1:0] m_mem [2][D];
  int  m_cnt [2];
  int  m_gen [2];
  int  m_fill;
  bit  m_busy, m_ovf, m_taken;
  int  seq = 0;
  logic [15:0] lfsr = 16'hACE1;

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [W-1:0] val(input int k, input int c);
    return 32'h3F80_0000 + 32'(k) * 32'h0000_1003 + 32'(c) * 32'h0010_0000;
  endfunction

  function automatic logic [127:0] exp_row(input int cnt, input int id, input int gen);
    logic [7:0] b [16];
    logic [127:0] r;
    for (int i = 0; i < 16; i++) b[i] = 8'h00;
    b[0] = 8'(cnt);
    b[1] = 8'(cnt >> 8);
    b[2] = 8'(id);
    b[3] = 8'(gen);
    for (int i = 0; i < 15; i++) b[15] = b[15] ^ b[i];
    for (int i = 0; i < 16; i++) r[8*i +: 8] = b[i];
    return r;
  endfunction

  task automatic status(input string tag);
    int dr;
    dr = 1 - m_fill;
    check({"R4 fill_bank ", tag}, 128'(fill_bank), 128'(m_fill));
    check({"R2 fill_count ", tag}, 128'(fill_count), 128'(m_cnt[m_fill]));
    check({"R2 drain_count ", tag}, 128'(drain_count), 128'(m_cnt[dr]));
    check({"R8 drain_busy ", tag}, 128'(drain_busy), 128'(m_busy));
    check({"R6 overflow ", tag}, 128'(overflow), 128'(m_ovf));
    check({"R4 swap_taken ", tag}, 128'(swap_taken), 128'(m_taken));
    check({"R3 fill_index ", tag}, fill_index, exp_row(m_cnt[m_fill], m_fill, m_gen[m_fill]));
    check({"R3 drain_index ", tag}, drain_index, exp_row(m_cnt[dr], dr, m_gen[dr]));
  endtask

  // One clock with the given controls, model update, then checks
  task automatic cyc(input bit w, input bit s, input bit r, input string tag);
    bit take;
    wr_en = w; swap_req = s; drain_release = r;
    wr_fx = val(seq, 0); wr_fy = val(seq, 1); wr_fz = val(seq, 2);
    take = (s || (w && m_cnt[m_fill] == D)) && !m_busy;
    m_taken = take;
    if (take) begin
      m_fill = 1 - m_fill;
      m_cnt[m_fill] = 0;
      m_gen[m_fill] = (m_gen[m_fill] + 1) % 256;
      m_busy = 1'b1;
    end else if (r) begin
      m_busy = 1'b0;
    end
    if (w) begin
      if (m_cnt[m_fill] < D) begin
        m_mem[m_fill][m_cnt[m_fill]] = {val(seq, 2), val(seq, 1), val(seq, 0)};
        m_cnt[m_fill]++;
      end else begin
        m_ovf = 1'b1;
      end
    end
    seq++;
    @(negedge clk);
    wr_en = 1'b0; swap_req = 1'b0; drain_release = 1'b0;
    status(tag);
  endtask

  task automatic drain_sweep(input string tag);
    int dr;
    logic [3*W-1:0] e;
    dr = 1 - m_fill;
    for (int a = 0; a < (1 << CW); a++) begin
      rd_addr = CW'(a);
      e = (a < m_cnt[dr]) ? m_mem[dr][a] : '0;
      @(negedge clk);
      m_taken = 1'b0;
      check({"R7 rd ", tag}, 128'({rd_fz, rd_fy, rd_fx}), 128'(e));
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    m_cnt[0] = 0; m_cnt[1] = 0; m_gen[0] = 0; m_gen[1] = 0;
    m_fill = 0; m_busy = 0; m_ovf = 0; m_taken = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    status("R1 reset");
    // R2/R3: fill bank 0
    for (int i = 0; i < D; i++) cyc(1, 0, 0, "R2 append");
    // R5: write into full bank with idle drain
    cyc(1, 0, 0, "R5 auto swap");
    drain_sweep("R7 bank0");
    // fill bank 1, then R6 drop
    for (int i = 0; i < D-1; i++) cyc(1, 0, 0, "R2 append b1");
    cyc(1, 0, 0, "R6 drop");
    cyc(0, 0, 0, "R6 sticky");
    // R4: swap request while held is ignored
    cyc(0, 1, 0, "R4 ignored");
    // R8: release, then release again with no effect
    cyc(0, 0, 1, "R8 release");
    cyc(0, 0, 1, "R8 idle release");
    // R9: swap with same-cycle write
    cyc(1, 1, 0, "R9 swap+write");
    drain_sweep("R7 bank1");
    cyc(0, 0, 1, "R8 release2");
    cyc(0, 1, 0, "R4 empty swap");
    // Mixed pseudo-random traffic
    for (int k = 0; k < 600; k++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      cyc(lfsr[0], lfsr[3:1] == 3'b111, lfsr[6:4] == 3'b101, "mix");
      if (k % 25 == 24) drain_sweep("R7 mix");
    end
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule